// File: doc/BRIEF.md
# Stereo DC Offset Trimmer with Hold

This block removes the DC component from a two-channel stream of signed PCM samples that arrive from a decimation stage with a valid strobe. For each channel it keeps a running estimate of the DC level in a first-order leaky integrator. It subtracts that estimate from every sample, and the result saturates to the sample range instead of wrapping.

Each channel has two control inputs, one to enable it and one to hold it. When a channel is held, its estimate stops adapting but is still subtracted. This supports system offset calibration: run with the hold released until the estimate settles, then assert the hold to keep that offset. When a channel is disabled, samples pass through unchanged so that true DC levels can be measured. The stored estimate is kept while the channel is disabled, and tracking resumes from that estimate when the channel is enabled again.

Top module: `dc_trim_stereo`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears both estimates to zero, drives `out_valid` low and drives both outputs to zero. The first enabled sample after reset is therefore passed through unchanged.
- R2: The estimator state `acc` is a signed value that is W+FRAC bits wide.
  - On a valid sample with the channel enabled and not held, `acc` becomes `acc + (((x << FRAC) - acc) >>> SHIFT)`, using arithmetic (floor) shifts.
  - The estimate is `acc >>> FRAC`.
  - The defaults are W=16 and SHIFT=FRAC=10.
- R3: When a channel is enabled, its output for a valid sample is `x - est`. The estimate used is the one held before this sample's own update. The output is registered with one cycle of latency.
- R4: While a channel's hold input is high, its estimate does not change, and the held estimate is still subtracted from each valid sample.
- R5: While a channel is disabled, its output equals its input sample and its estimate is not changed.
- R6: The difference `x - est` saturates to the range [-2^(W-1), 2^(W-1)-1]. With W=16 this range is [-32768, 32767].
- R7: `out_valid` is `in_valid` delayed by one cycle. On cycles with `in_valid` low, neither the estimates nor the output samples change.
- R8: After a channel is enabled again following a disabled stretch, subtraction and tracking continue from the estimate stored before it was disabled.
- R9: Channel A (`in_a`, `en_a`, `hold_a`, `out_a`) and channel B (`in_b`, `en_b`, `hold_b`, `out_b`) are independent. The controls and samples of one channel never affect the other channel's estimate or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe for both channels |
| in_a | input | W | Channel A sample, two's complement |
| in_b | input | W | Channel B sample, two's complement |
| en_a | input | 1 | Channel A offset removal enable |
| en_b | input | 1 | Channel B offset removal enable |
| hold_a | input | 1 | Channel A estimate hold |
| hold_b | input | 1 | Channel B estimate hold |
| out_valid | output | 1 | Output strobe, one cycle after in_valid |
| out_a | output | W | Channel A corrected sample |
| out_b | output | W | Channel B corrected sample |

## Verification
A wrong estimator state cannot be seen directly; it shows only through the subtracted value. The bench therefore compares every valid output against its own model of the integrator. Any drift in the estimate, such as an update on an invalid or held cycle or a wrong rounding, becomes an output mismatch on the very next valid sample.

Bypass hides the estimate, so after each disabled stretch the bench enables the channel again. The first sample after that exposes any estimate that changed while bypassed. Saturation errors show as a sign flip on the first sample whose difference leaves the range.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic enable;
    logic hold;
  } dct_ctrl_t;
endpackage

// File: rtl/dct_estimator.sv
module dct_estimator #(
  parameter int W     = 16,
  parameter int SHIFT = 10,
  parameter int FRAC  = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic                enable,
  input  logic                hold,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] est
);
  localparam int AW = W + FRAC;
  localparam int DW = AW + 1;

  logic signed [AW-1:0] acc_q;
  logic                 upd;

  function automatic logic signed [AW-1:0] leak_step(
    input logic signed [AW-1:0] acc,
    input logic signed [W-1:0]  smp
  );
    logic signed [DW-1:0] diff;
    logic signed [DW-1:0] stepv;
    diff  = (DW'(smp) <<< FRAC) - DW'(acc);
    stepv = diff >>> SHIFT;
    return acc + AW'(stepv);
  endfunction

  assign upd = valid && enable && !hold;
  assign est = acc_q[AW-1:FRAC];

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else if (upd) acc_q <= leak_step(acc_q, x);
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> acc_q == '0) else $error("estimate not cleared by reset");
  assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(acc_q)) else $error("estimate moved while held");
  assert_bypass_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(acc_q)) else $error("estimate moved while disabled");
  assert_idle_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(acc_q)) else $error("estimate moved without valid");
endmodule

// File: rtl/dct_out_stage.sv
module dct_out_stage #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  logic                enable,
  input  logic signed [W-1:0] x,
  input  logic signed [W-1:0] est,
  output logic signed [W-1:0] y
);
  localparam logic signed [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [W-1:0] sat_sub(
    input logic signed [W-1:0] a,
    input logic signed [W-1:0] b
  );
    logic signed [W:0] d;
    d = {a[W-1], a} - {b[W-1], b};
    if (d[W] != d[W-1]) return d[W] ? MINV : MAXV;
    return d[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) y <= '0;
    else if (valid) y <= enable ? sat_sub(x, est) : x;
  end

  assert_bypass_passes_R5: assert property (@(posedge clk) disable iff (rst)
    (valid && !enable) |=> y == $past(x)) else $error("bypass altered sample");
  assert_no_wrap_pos_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && enable && !x[W-1] && est[W-1]) |=> !y[W-1])
    else $error("positive difference wrapped");
  assert_no_wrap_neg_R6: assert property (@(posedge clk) disable iff (rst)
    (valid && enable && x[W-1] && !est[W-1]) |=> y[W-1])
    else $error("negative difference wrapped");
  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(y)) else $error("output changed without valid");
endmodule

// File: rtl/dct_channel.sv
module dct_channel
  import dct_pkg::*;
#(
  parameter int W     = 16,
  parameter int SHIFT = 10,
  parameter int FRAC  = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                valid,
  input  dct_ctrl_t           ctl,
  input  logic signed [W-1:0] x,
  output logic signed [W-1:0] y
);
  logic signed [W-1:0] est;

  dct_estimator #(.W(W), .SHIFT(SHIFT), .FRAC(FRAC)) i_est (
    .clk(clk), .rst(rst), .valid(valid), .enable(ctl.enable),
    .hold(ctl.hold), .x(x), .est(est)
  );

  dct_out_stage #(.W(W)) i_out (
    .clk(clk), .rst(rst), .valid(valid), .enable(ctl.enable),
    .x(x), .est(est), .y(y)
  );
endmodule

// File: rtl/dc_trim_stereo.sv
module dc_trim_stereo
  import dct_pkg::*;
#(
  parameter int W     = 16,
  parameter int SHIFT = 10,
  parameter int FRAC  = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         en_a,
  input  logic         en_b,
  input  logic         hold_a,
  input  logic         hold_b,
  output logic         out_valid,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b
);
  logic signed [W-1:0] x_arr [NUM_CH];
  logic signed [W-1:0] y_arr [NUM_CH];
  dct_ctrl_t           ctl   [NUM_CH];

  assign x_arr[0] = in_a;
  assign x_arr[1] = in_b;
  assign ctl[0]   = '{enable: en_a, hold: hold_a};
  assign ctl[1]   = '{enable: en_b, hold: hold_b};
  assign out_a    = y_arr[0];
  assign out_b    = y_arr[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dct_channel #(.W(W), .SHIFT(SHIFT), .FRAC(FRAC)) i_ch (
      .clk(clk), .rst(rst), .valid(in_valid), .ctl(ctl[c]),
      .x(x_arr[c]), .y(y_arr[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else out_valid <= in_valid;
  end

  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid) else $error("out_valid missing");
  assert_valid_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid) else $error("spurious out_valid");
endmodule

// File: tb/test_dc_trim_stereo.sv
module test_dc_trim_stereo;
  localparam int W = 16;
  localparam int SHIFT = 10;
  localparam int FRAC = 10;
  localparam time CLK_PERIOD = 10ns;
  localparam longint MAXV = 32767;
  localparam longint MINV = -32768;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic en_a = 1'b0, en_b = 1'b0, hold_a = 1'b0, hold_b = 1'b0;
  logic out_valid;
  logic [W-1:0] out_a, out_b;

  int checks = 0;
  int errors = 0;
  longint acc_m [2];
  longint exp_y [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dc_trim_stereo #(.W(W), .SHIFT(SHIFT), .FRAC(FRAC)) i_dc_trim_stereo (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
    .en_a(en_a), .en_b(en_b), .hold_a(hold_a), .hold_b(hold_b),
    .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
  );

  function automatic longint clampv(longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives one cycle and checks at the next falling edge.
  task automatic step(string req, bit v, int xa, int xb,
                      bit ea, bit eb, bit ha, bit hb);
    int xs [2];
    bit es [2];
    bit hs [2];
    xs[0] = xa; xs[1] = xb; es[0] = ea; es[1] = eb; hs[0] = ha; hs[1] = hb;
    in_valid = v; in_a = W'(xa); in_b = W'(xb);
    en_a = ea; en_b = eb; hold_a = ha; hold_b = hb;
    for (int c = 0; c < 2; c++) begin
      if (v) begin
        exp_y[c] = es[c] ? clampv(longint'(xs[c]) - (acc_m[c] >>> FRAC))
                         : longint'(xs[c]);
        if (es[c] && !hs[c])
          acc_m[c] = acc_m[c] + (((longint'(xs[c]) <<< FRAC) - acc_m[c]) >>> SHIFT);
      end
    end
    @(negedge clk);
    check({req, " out_valid"}, longint'(out_valid), longint'(v));
    check({req, " out_a"}, longint'($signed(out_a)), exp_y[0]);
    check({req, " out_b"}, longint'($signed(out_b)), exp_y[1]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_a = 16'h1234; in_b = 16'h4321;
    en_a = 1'b1; en_b = 1'b1; hold_a = 1'b0; hold_b = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
    acc_m[0] = 0; acc_m[1] = 0; exp_y[0] = 0; exp_y[1] = 0;
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 out_a after reset", longint'($signed(out_a)), 0);
    check("R1 out_b after reset", longint'($signed(out_b)), 0);
  endtask

  task automatic t_reset();
    do_reset();
    step("R1 first sample passes", 1, 500, -321, 1, 1, 0, 0);
    check("R1 out_a literal", longint'($signed(out_a)), 500);
  endtask

  task automatic t_bypass();
    do_reset();
    for (int i = 0; i < 50; i++) step("R5 bypass", 1, 2000, -1500, 0, 0, 0, 0);
    check("R5 bypass literal", longint'($signed(out_a)), 2000);
    step("R5 estimate untouched", 1, 2000, -1500, 1, 1, 0, 0);
    check("R5 estimate untouched literal", longint'($signed(out_b)), -1500);
  endtask

  task automatic t_track();
    do_reset();
    for (int i = 0; i < 3000; i++) step("R2 R3 tracking", 1, 1000, -700, 1, 1, 0, 0);
    checks++;
    if ($signed(out_a) > 100 || $signed(out_a) < 0) begin
      errors++;
      $display("FAIL R2 settled actual %0d expected 0..100", $signed(out_a));
    end
  endtask

  task automatic t_freeze();
    step("R4 hold", 1, 1000, -700, 1, 1, 1, 1);
    for (int i = 0; i < 200; i++)
      step("R4 hold varying", 1, (i % 3 - 1) * 1500, i * 7, 1, 1, 1, 1);
    step("R4 hold repeat a", 1, 1234, 55, 1, 1, 1, 1);
    step("R4 hold repeat b", 1, 1234, 55, 1, 1, 1, 1);
  endtask

  task automatic t_resume();
    for (int i = 0; i < 100; i++) step("R8 disabled", 1, -5000, 300, 0, 1, 0, 0);
    for (int i = 0; i < 100; i++) step("R8 resumed", 1, 1000, 300, 1, 1, 0, 0);
  endtask

  task automatic t_valid();
    step("R7 prime", 1, 800, -800, 1, 1, 0, 0);
    for (int i = 0; i < 20; i++)
      step("R7 idle", 0, 30000 - i * 1000, -30000 + i, 1, 1, 0, 0);
    step("R7 after idle", 1, 800, -800, 1, 1, 0, 0);
  endtask

  task automatic t_indep();
    for (int i = 0; i < 300; i++) step("R9 A tracks B bypass", 1, 4000, 9000, 1, 0, 0, 0);
    for (int i = 0; i < 300; i++) step("R9 A held B tracks", 1, -2000, 9000, 1, 1, 1, 0);
  endtask

  task automatic t_sat();
    do_reset();
    for (int i = 0; i < 4096; i++) step("R6 train", 1, -32768, 32767, 1, 1, 0, 0);
    step("R6 positive clip", 1, 32767, -32768, 1, 1, 1, 1);
    check("R6 positive clip literal", longint'($signed(out_a)), 32767);
    check("R6 negative clip literal", longint'($signed(out_b)), -32768);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_track();
    t_freeze();
    t_resume();
    t_valid();
    t_indep();
    t_sat();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule